// File: doc/BRIEF.md
# Fault escalation and lockup controller

This block is the fault-handling state machine of a small processor core. It receives single-cycle fault strobes, the current execution context, NMI and reset requests, a debugger halt request, and the exception-return value that is presented when a handler exits. Every fault is funnelled into one fixed-priority HardFault request. The block enforces the preemption order between NMI and HardFault. A fault that arrives while the core already runs the HardFault or NMI handler does not nest. It freezes the core in a lockup state, during which instruction fetch is held off.

The controller also decodes the exception-return value into a target mode and a stack choice. A reserved value is treated as one more fault. A bus error while unstacking from the main stack locks the core immediately. Lockup ends only on a reset request, on a debugger halt, or on an NMI when the lockup started inside the HardFault handler. All outputs are registered, so each response appears one clock after the inputs that cause it.

Top module: `fault_lockup_ctrl`

## Requirements
- R1: Outside lockup, with context base (ctx_i 2'b00, or the spare code 2'b11) and no NMI request, any fault strobe gives a one-cycle hf_take_o pulse on the next cycle. Several strobes in the same cycle give a single pulse.
- R2: Outside lockup, an NMI request in base context or in the HardFault handler (ctx_i 2'b01) gives nmi_take_o on the next cycle. In the NMI handler (ctx_i 2'b10) it gives nothing. When an NMI and a fault arrive together in base context, only nmi_take_o pulses.
- R3: A fault in the HardFault or NMI handler sets lockup_o on the next cycle and produces no take pulse.
- R4: An exception return whose value selects the main stack (32'hFFFF_FFF1 or 32'hFFFF_FFF9) and that comes with unstack_err_i enters lockup in any context. The same error with 32'hFFFF_FFFD counts as an ordinary fault.
- R5: While lockup_o is high, halt_fetch_o is high and no take pulse or return decode is issued. Faults and returns change nothing.
- R6: dbg_halt_i during lockup clears lockup on the next cycle with no take pulse, and the lockup origin is forgotten. Outside lockup dbg_halt_i has no effect.
- R7: An NMI request ends a lockup that began in the HardFault handler and pulses nmi_take_o. It does not end a lockup that began in the NMI handler.
- R8: A valid return of 32'hFFFF_FFF1 gives ret_valid_o=1, ret_handler_o=1, ret_psp_o=0 one cycle later. 32'hFFFF_FFF9 gives 1,0,0 and 32'hFFFF_FFFD gives 1,0,1.
- R9: Any other return value is reserved. It gives no ret_valid_o and is handled as a fault under R1 and R3.
- R10: rst_req_i takes priority over every other input and clears lockup and all outputs on the next cycle. rst_ni clears the same state asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Synchronous system reset request |
| fault_i | input | NUM_FAULTS | Single-cycle fault strobes, one per fault class |
| ctx_i | input | 2 | Context: 00 base, 01 HardFault handler, 10 NMI handler, 11 as base |
| nmi_req_i | input | 1 | NMI request |
| dbg_halt_i | input | 1 | Debugger halt request |
| exc_ret_valid_i | input | 1 | Exception-return value present |
| exc_ret_i | input | 32 | Exception-return value |
| unstack_err_i | input | 1 | Bus error while unstacking status during this return |
| hf_take_o | output | 1 | Take HardFault |
| nmi_take_o | output | 1 | Take NMI |
| lockup_o | output | 1 | Core locked up |
| halt_fetch_o | output | 1 | Stop instruction fetch |
| ret_valid_o | output | 1 | Decoded return is valid |
| ret_handler_o | output | 1 | Return to handler mode |
| ret_psp_o | output | 1 | Return uses the process stack |

## Verification
The hardest state to reach is a lockup whose origin matters. The bench has to tell apart a lockup begun in the NMI handler from one begun in the HardFault handler. It must also show that a debugger exit erases that origin. The directed stimulus enters lockup from the NMI context and shows that an NMI does not release it. It then leaves by debug halt, locks again from the HardFault context and releases with an NMI. A long random phase follows, with rare faults, context changes and return values. The model tracks the lockup origin across these combinations. Each clock is compared against that model.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    CTX_BASE = 2'b00,
    CTX_HARD = 2'b01,
    CTX_NMI  = 2'b10,
    CTX_SPARE = 2'b11
  } ctx_e;

  localparam int unsigned RET_W = 32;
  localparam logic [RET_W-1:0] RET_HND_MSP = 32'hFFFF_FFF1;
  localparam logic [RET_W-1:0] RET_THR_MSP = 32'hFFFF_FFF9;
  localparam logic [RET_W-1:0] RET_THR_PSP = 32'hFFFF_FFFD;

  typedef struct packed {
    logic known;
    logic to_handler;
    logic use_psp;
  } ret_dec_t;
endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
  import flc_pkg::*;
(
  input  logic [RET_W-1:0] value_i,
  output ret_dec_t         dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (value_i)
      RET_HND_MSP: dec_o = '{known: 1'b1, to_handler: 1'b1, use_psp: 1'b0};
      RET_THR_MSP: dec_o = '{known: 1'b1, to_handler: 1'b0, use_psp: 1'b0};
      RET_THR_PSP: dec_o = '{known: 1'b1, to_handler: 1'b0, use_psp: 1'b1};
      default:     dec_o = '0;
    endcase
  end
endmodule

// File: rtl/fault_merge.sv
module fault_merge
  import flc_pkg::*;
#(
  parameter int unsigned NUM_FAULTS = 9
) (
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  ret_valid_i,
  input  ret_dec_t              dec_i,
  input  logic                  unstack_err_i,
  output logic                  fault_any_o,
  output logic                  msp_lock_o,
  output logic                  ret_ok_o
);
  logic reserved_ret, psp_err;

  assign reserved_ret = ret_valid_i & ~dec_i.known;
  assign psp_err      = ret_valid_i & dec_i.known & dec_i.use_psp & unstack_err_i;
  assign msp_lock_o   = ret_valid_i & dec_i.known & ~dec_i.use_psp & unstack_err_i;
  // all classes collapse into one escalation
  assign fault_any_o  = (|fault_i) | reserved_ret | psp_err;
  assign ret_ok_o     = ret_valid_i & dec_i.known & ~unstack_err_i;
endmodule

// File: rtl/lockup_fsm.sv
module lockup_fsm
  import flc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rst_req_i,
  input  logic     fault_any_i,
  input  logic     msp_lock_i,
  input  ctx_e     ctx_i,
  input  logic     nmi_req_i,
  input  logic     dbg_halt_i,
  input  logic     ret_ok_i,
  input  ret_dec_t dec_i,
  output logic     hf_take_o,
  output logic     nmi_take_o,
  output logic     lockup_o,
  output logic     ret_valid_o,
  output logic     ret_handler_o,
  output logic     ret_psp_o
);
  logic lock_q, lock_d, org_nmi_q, org_nmi_d;
  logic hf_q, hf_d, nmi_q, nmi_d;
  logic rv_q, rv_d, rh_q, rh_d, rp_q, rp_d;
  logic in_handler, lock_now;

  assign in_handler = (ctx_i == CTX_HARD) || (ctx_i == CTX_NMI);
  assign lock_now   = msp_lock_i | (fault_any_i & in_handler);

  always_comb begin
    lock_d    = lock_q;
    org_nmi_d = org_nmi_q;
    hf_d  = 1'b0;
    nmi_d = 1'b0;
    rv_d  = 1'b0;
    rh_d  = 1'b0;
    rp_d  = 1'b0;
    if (rst_req_i) begin
      lock_d    = 1'b0;
      org_nmi_d = 1'b0;
    end else if (lock_q) begin
      if (dbg_halt_i) begin
        lock_d    = 1'b0;
        org_nmi_d = 1'b0;
      end else if (nmi_req_i && !org_nmi_q) begin
        lock_d    = 1'b0;
        org_nmi_d = 1'b0;
        nmi_d     = 1'b1;
      end
    end else if (lock_now) begin
      lock_d    = 1'b1;
      org_nmi_d = (ctx_i == CTX_NMI);
    end else begin
      nmi_d = nmi_req_i && (ctx_i != CTX_NMI);
      hf_d  = fault_any_i && !nmi_req_i;
      rv_d  = ret_ok_i;
      rh_d  = ret_ok_i & dec_i.to_handler;
      rp_d  = ret_ok_i & dec_i.use_psp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      org_nmi_q <= 1'b0;
      hf_q      <= 1'b0;
      nmi_q     <= 1'b0;
      rv_q      <= 1'b0;
      rh_q      <= 1'b0;
      rp_q      <= 1'b0;
    end else begin
      lock_q    <= lock_d;
      org_nmi_q <= org_nmi_d;
      hf_q      <= hf_d;
      nmi_q     <= nmi_d;
      rv_q      <= rv_d;
      rh_q      <= rh_d;
      rp_q      <= rp_d;
    end
  end

  assign hf_take_o     = hf_q;
  assign nmi_take_o    = nmi_q;
  assign lockup_o      = lock_q;
  assign ret_valid_o   = rv_q;
  assign ret_handler_o = rh_q;
  assign ret_psp_o     = rp_q;

  assert_single_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hf_q, nmi_q}));
  assert_quiet_in_lockup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (!hf_q && !nmi_q && !rv_q));
  assert_handler_fault_locks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_i && !lock_q && fault_any_i && in_handler) |=> lock_q);
  assert_nmi_origin_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && org_nmi_q && !dbg_halt_i && !rst_req_i) |=> lock_q);
  assert_dbg_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && dbg_halt_i && !rst_req_i) |=> (!lock_q && !nmi_q));
  assert_reset_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (!lock_q && !hf_q && !nmi_q && !rv_q));
  assert_ret_mode_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_q |-> !(rh_q && rp_q));
endmodule

// File: rtl/fault_lockup_ctrl.sv
module fault_lockup_ctrl
  import flc_pkg::*;
#(
  parameter int unsigned NUM_FAULTS = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rst_req_i,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic [1:0]            ctx_i,
  input  logic                  nmi_req_i,
  input  logic                  dbg_halt_i,
  input  logic                  exc_ret_valid_i,
  input  logic [31:0]           exc_ret_i,
  input  logic                  unstack_err_i,
  output logic                  hf_take_o,
  output logic                  nmi_take_o,
  output logic                  lockup_o,
  output logic                  halt_fetch_o,
  output logic                  ret_valid_o,
  output logic                  ret_handler_o,
  output logic                  ret_psp_o
);
  ret_dec_t dec;
  logic fault_any, msp_lock, ret_ok, lock;

  exc_ret_decode u_dec (
    .value_i (exc_ret_i),
    .dec_o   (dec)
  );

  fault_merge #(.NUM_FAULTS(NUM_FAULTS)) u_merge (
    .fault_i       (fault_i),
    .ret_valid_i   (exc_ret_valid_i),
    .dec_i         (dec),
    .unstack_err_i (unstack_err_i),
    .fault_any_o   (fault_any),
    .msp_lock_o    (msp_lock),
    .ret_ok_o      (ret_ok)
  );

  lockup_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_req_i     (rst_req_i),
    .fault_any_i   (fault_any),
    .msp_lock_i    (msp_lock),
    .ctx_i         (ctx_e'(ctx_i)),
    .nmi_req_i     (nmi_req_i),
    .dbg_halt_i    (dbg_halt_i),
    .ret_ok_i      (ret_ok),
    .dec_i         (dec),
    .hf_take_o     (hf_take_o),
    .nmi_take_o    (nmi_take_o),
    .lockup_o      (lock),
    .ret_valid_o   (ret_valid_o),
    .ret_handler_o (ret_handler_o),
    .ret_psp_o     (ret_psp_o)
  );

  assign lockup_o     = lock;
  assign halt_fetch_o = lock;

  assert_msp_unstack_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_i && !lock && exc_ret_valid_i && unstack_err_i &&
     (exc_ret_i == RET_HND_MSP || exc_ret_i == RET_THR_MSP)) |=> lockup_o);
endmodule

// File: tb/sim_fault_lockup_ctrl.sv
module sim_fault_lockup_ctrl;
  localparam int NF = 9;
  localparam logic [31:0] V_F1 = 32'hFFFF_FFF1, V_F9 = 32'hFFFF_FFF9, V_FD = 32'hFFFF_FFFD;

  logic clk = 0, rst_ni = 0;
  logic rst_req = 0, nmi = 0, dbg = 0, rv = 0, uerr = 0;
  logic [NF-1:0] flt = '0;
  logic [1:0] ctx = 2'b00;
  logic [31:0] rval = '0;
  logic hf_o, nmi_o, lock_o, halt_o, rv_o, rh_o, rp_o;

  int checks = 0, failures = 0;
  bit m_lock = 0, m_org = 0, e_hf = 0, e_nmi = 0, e_rv = 0, e_rh = 0, e_rp = 0;

  always #10 clk = ~clk;

  fault_lockup_ctrl #(.NUM_FAULTS(NF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .fault_i(flt), .ctx_i(ctx),
    .nmi_req_i(nmi), .dbg_halt_i(dbg), .exc_ret_valid_i(rv), .exc_ret_i(rval),
    .unstack_err_i(uerr), .hf_take_o(hf_o), .nmi_take_o(nmi_o), .lockup_o(lock_o),
    .halt_fetch_o(halt_o), .ret_valid_o(rv_o), .ret_handler_o(rh_o), .ret_psp_o(rp_o)
  );

  task automatic model_step();
    bit legal, any_f, mlock, hctx;
    legal = (rval == V_F1) || (rval == V_F9) || (rval == V_FD);
    mlock = rv && uerr && (rval == V_F1 || rval == V_F9);
    any_f = (flt != 0) || (rv && !legal) || (rv && uerr && rval == V_FD);
    hctx  = (ctx == 2'b01) || (ctx == 2'b10);
    {e_hf, e_nmi, e_rv, e_rh, e_rp} = '0;
    if (rst_req) begin
      m_lock = 0; m_org = 0;
    end else if (m_lock) begin
      if (dbg) begin m_lock = 0; m_org = 0; end
      else if (nmi && !m_org) begin m_lock = 0; e_nmi = 1; end
    end else if (mlock || (any_f && hctx)) begin
      m_lock = 1; m_org = (ctx == 2'b10);
    end else begin
      e_nmi = nmi && ctx != 2'b10;
      e_hf  = any_f && !nmi;
      if (rv && legal && !uerr) begin
        e_rv = 1; e_rh = (rval == V_F1); e_rp = (rval == V_FD);
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [6:0] act, exp;
    act = {hf_o, nmi_o, lock_o, halt_o, rv_o, rh_o, rp_o};
    exp = {e_hf, e_nmi, m_lock, m_lock, e_rv, e_rh, e_rp};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s hf,nmi,lock,halt,rv,rh,rp actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_strobes();
    flt = '0; nmi = 0; dbg = 0; rv = 0; uerr = 0; rst_req = 0; rval = '0;
  endtask

  task automatic ret(input logic [31:0] v, input bit err, input string tag);
    rv = 1; rval = v; uerr = err; cyc(tag); clear_strobes();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 async reset");
    rst_ni = 1;
    cyc("R10 idle after reset");

    // R1: single and merged faults in base context
    ctx = 2'b00; flt = 9'h004; cyc("R1 single fault"); clear_strobes();
    cyc("R1 pulse ends");
    flt = 9'h1A1; cyc("R1 merged faults"); clear_strobes();
    cyc("R1 merged single pulse");
    ctx = 2'b11; flt = 9'h100; cyc("R1 spare ctx"); clear_strobes();

    // R2
    ctx = 2'b00; nmi = 1; cyc("R2 nmi base"); clear_strobes();
    ctx = 2'b01; nmi = 1; cyc("R2 nmi preempts hard"); clear_strobes();
    ctx = 2'b10; nmi = 1; cyc("R2 nmi in nmi"); clear_strobes();
    ctx = 2'b00; nmi = 1; flt = 9'h002; cyc("R2 nmi beats fault"); clear_strobes();

    // R6 no effect outside lockup
    dbg = 1; cyc("R6 dbg idle"); clear_strobes();

    // R8 / R9
    ret(V_F1, 0, "R8 handler msp");
    ret(V_F9, 0, "R8 thread msp");
    ret(V_FD, 0, "R8 thread psp");
    ret(32'hFFFF_FFF5, 0, "R9 reserved escalates");
    ret(32'h0000_0000, 0, "R9 reserved zero");

    // R3 + R5 + R7: lockup from HardFault, NMI releases
    ctx = 2'b01; flt = 9'h010; cyc("R3 fault in hard"); clear_strobes();
    flt = 9'h1FF; cyc("R5 faults ignored"); clear_strobes();
    ctx = 2'b00; ret(V_F1, 0, "R5 return ignored");
    flt = 9'h001; cyc("R5 base fault ignored"); clear_strobes();
    nmi = 1; cyc("R7 nmi exits hard lockup"); clear_strobes();
    cyc("R7 after exit");

    // R7 + R6: lockup from NMI handler
    ctx = 2'b10; ret(32'h1234_5678, 0, "R9 reserved in nmi locks");
    ctx = 2'b00;
    nmi = 1; cyc("R7 nmi keeps nmi lockup"); clear_strobes();
    nmi = 1; cyc("R7 nmi keeps nmi lockup again"); clear_strobes();
    dbg = 1; nmi = 1; cyc("R6 dbg exits"); clear_strobes();
    ctx = 2'b01; flt = 9'h008; cyc("R6 relock from hard"); clear_strobes();
    nmi = 1; cyc("R6 origin was cleared"); clear_strobes();

    // R4
    ctx = 2'b00; ret(V_F9, 1, "R4 msp unstack error");
    cyc("R4 held");
    rst_req = 1; nmi = 1; flt = 9'h003; cyc("R10 reset request"); clear_strobes();
    ret(V_F1, 1, "R4 msp handler unstack");
    dbg = 1; cyc("R6 exit"); clear_strobes();
    ret(V_FD, 1, "R4 psp error is fault");
    ctx = 2'b01; ret(V_FD, 1, "R4 psp error in hard locks");
    rst_req = 1; cyc("R10 clears"); clear_strobes();

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ctx = 2'($urandom_range(0, 3));
      flt = (r < 12) ? NF'($urandom) : '0;
      nmi = ($urandom_range(0, 99) < 8);
      dbg = ($urandom_range(0, 99) < 4);
      rst_req = ($urandom_range(0, 99) < 2);
      rv = ($urandom_range(0, 99) < 15);
      case ($urandom_range(0, 3))
        0: rval = V_F1;
        1: rval = V_F9;
        2: rval = V_FD;
        default: rval = $urandom;
      endcase
      uerr = rv && ($urandom_range(0, 99) < 10);
      cyc("R1 R2 R3 R5 R7 R9 mixed");
    end
    clear_strobes();
    cyc("R10 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule